// File: doc/BRIEF.md
# Hardware Performance Monitor Counter Bank

This block holds a parameterised set of 64-bit event counters for a processor core. Each counter owns an event-selection mask over a vector of single-cycle event pulses that the pipeline supplies. A shared control register holds one enable bit per counter. In a cycle where the counter's enable bit is set, the core is awake, and at least one masked event pulse is high, the counter advances by exactly one. It advances by one no matter how many of its selected events fire together.

Software reaches the counters, the selectors and the control register through a simple register port with a 7-bit address, a write strobe and a combinational read path. A counter is read or written as two 32-bit halves. Counters occupy indices 3 up to 3+NUM_CNT-1, and the enable bit for a counter sits at the control bit with the same index. Indices with no counter behind them read as zero.

Top module: `hpm_bank`

## Requirements
- R1: After reset, every counter word, every selector and the control register read as zero.
- R2: An enabled counter whose mask (selector AND event vector) is non-zero in a cycle, while sleep is low and no write is made, increments by exactly one, even when several selected events fire together.
- R3: Events whose bits are clear in a counter's selector do not change that counter.
- R4: While sleep_i is high, no counter changes.
- R5: Control bit i (i = 3 .. 3+NUM_CNT-1) enables counter index i. While that bit is 0, the counter holds.
- R6: When the low word wraps from 0xFFFFFFFF to 0, the high word increments on the same clock edge.
- R7: A write to either word of a counter takes priority over that cycle's increment. The written word takes the write data and the other word holds.
- R8: Counter and selector indices below 3 or at or above 3+NUM_CNT read as zero, and writes to them change nothing.
- R9: Control bits outside 3 .. 3+NUM_CNT-1 and selector bits at or above EVT_W read as zero whatever was written.
- R10: Address encoding: csr_addr_i[6:5] selects the space (00 counter low word, 01 counter high word, 10 event selector, 11 control register, where the index is ignored). csr_addr_i[4:0] is the index. csr_rdata_o is a combinational function of the address and the current state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | EVT_W | Per-cycle event pulses |
| sleep_i | input | 1 | Core asleep; freezes all counting |
| csr_we_i | input | 1 | Register write strobe |
| csr_addr_i | input | 7 | Register address (space and index) |
| csr_wdata_i | input | 32 | Register write data |
| csr_rdata_o | output | 32 | Register read data |

## Verification
The counter and selector state is visible only through the read port. A bad increment, a missed carry or a counter that ignores sleep or its enable bit therefore appears on the first read of the affected word after the cycle where the fault occurred. The checks read every word touched by a stimulus phase before the next phase starts. This keeps a wrong step count tied to one pattern of events, sleep and enables. Write priority and carry are checked on the edge where they happen, by reading the counter one cycle later.

// File: rtl/hpm_pkg.sv
package hpm_pkg;
   localparam int DATA_W    = 32;
   localparam int IDX_W     = 5;
   localparam int ADDR_W    = 2 + IDX_W;
   localparam int FIRST_IDX = 3;
   localparam int MAX_CNT   = 32 - FIRST_IDX;

   typedef enum logic [1:0] {
      SP_LO  = 2'b00,
      SP_HI  = 2'b01,
      SP_SEL = 2'b10,
      SP_CTL = 2'b11
   } space_e;

   function automatic space_e addr_space(input logic [ADDR_W-1:0] a);
      return space_e'(a[ADDR_W-1:IDX_W]);
   endfunction

   function automatic logic [IDX_W-1:0] addr_index(input logic [ADDR_W-1:0] a);
      return a[IDX_W-1:0];
   endfunction
endpackage

// File: rtl/hpm_cell.sv
module hpm_cell #(
   parameter int EVT_W = 8
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [EVT_W-1:0]          evt_i,
   input  logic                      sleep_i,
   input  logic                      en_i,
   input  logic                      wr_lo_i,
   input  logic                      wr_hi_i,
   input  logic                      wr_sel_i,
   input  logic [hpm_pkg::DATA_W-1:0] wdata_i,
   output logic [2*hpm_pkg::DATA_W-1:0] cnt_o,
   output logic [EVT_W-1:0]          sel_o
);
   import hpm_pkg::*;

   logic [DATA_W-1:0] lo_q, hi_q;
   logic [EVT_W-1:0]  sel_q;
   logic              step;
   logic              wr_any;
   logic              lo_wrap;

   assign step    = en_i && !sleep_i && (|(sel_q & evt_i));
   assign wr_any  = wr_lo_i || wr_hi_i;
   assign lo_wrap = &lo_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_q  <= '0;
         hi_q  <= '0;
         sel_q <= '0;
      end else begin
         if (wr_sel_i) sel_q <= wdata_i[EVT_W-1:0];
         if (wr_lo_i)  lo_q  <= wdata_i;
         if (wr_hi_i)  hi_q  <= wdata_i;
         if (!wr_any && step) begin
            lo_q <= lo_q + 1'b1;
            if (lo_wrap) hi_q <= hi_q + 1'b1;
         end
      end
   end

   assign cnt_o = {hi_q, lo_q};
   assign sel_o = sel_q;
endmodule

// File: rtl/hpm_ctl.sv
module hpm_ctl #(
   parameter int NUM_CNT = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_i,
   input  logic [hpm_pkg::DATA_W-1:0] wdata_i,
   output logic [NUM_CNT-1:0]         en_o,
   output logic [hpm_pkg::DATA_W-1:0] rd_o
);
   import hpm_pkg::*;

   localparam int LAST_IDX = FIRST_IDX + NUM_CNT - 1;

   logic [NUM_CNT-1:0] en_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    en_q <= '0;
      else if (wr_i) en_q <= wdata_i[LAST_IDX:FIRST_IDX];
   end

   generate
      if (LAST_IDX == DATA_W - 1) begin : g_full
         assign rd_o = {en_q, {FIRST_IDX{1'b0}}};
      end else begin : g_part
         assign rd_o = {{(DATA_W-1-LAST_IDX){1'b0}}, en_q, {FIRST_IDX{1'b0}}};
      end
   endgenerate

   assign en_o = en_q;
endmodule

// File: rtl/hpm_rdmux.sv
module hpm_rdmux #(
   parameter int NUM_CNT = 4,
   parameter int EVT_W   = 8
) (
   input  hpm_pkg::space_e                              space_i,
   input  logic [hpm_pkg::IDX_W-1:0]                    idx_i,
   input  logic [NUM_CNT-1:0][2*hpm_pkg::DATA_W-1:0]    cnt_i,
   input  logic [NUM_CNT-1:0][EVT_W-1:0]                sel_i,
   input  logic [hpm_pkg::DATA_W-1:0]                   ctl_i,
   output logic [hpm_pkg::DATA_W-1:0]                   rdata_o
);
   import hpm_pkg::*;

   always_comb begin
      rdata_o = '0;
      if (space_i == SP_CTL) begin
         rdata_o = ctl_i;
      end else begin
         for (int k = 0; k < NUM_CNT; k++) begin
            if (idx_i == IDX_W'(k + FIRST_IDX)) begin
               unique case (space_i)
                  SP_LO:   rdata_o = cnt_i[k][DATA_W-1:0];
                  SP_HI:   rdata_o = cnt_i[k][2*DATA_W-1:DATA_W];
                  SP_SEL:  rdata_o = DATA_W'(sel_i[k]);
                  default: rdata_o = '0;
               endcase
            end
         end
      end
   end
endmodule

// File: rtl/hpm_bank.sv
module hpm_bank #(
   parameter int NUM_CNT = 4,
   parameter int EVT_W   = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [EVT_W-1:0]           evt_i,
   input  logic                       sleep_i,
   input  logic                       csr_we_i,
   input  logic [hpm_pkg::ADDR_W-1:0] csr_addr_i,
   input  logic [hpm_pkg::DATA_W-1:0] csr_wdata_i,
   output logic [hpm_pkg::DATA_W-1:0] csr_rdata_o
);
   import hpm_pkg::*;

   generate
      if (NUM_CNT < 1 || NUM_CNT > MAX_CNT) begin : g_bad_cnt
         $error("hpm_bank: NUM_CNT out of range");
      end
      if (EVT_W < 1 || EVT_W > DATA_W) begin : g_bad_evt
         $error("hpm_bank: EVT_W out of range");
      end
   endgenerate

   space_e                              space;
   logic [IDX_W-1:0]                    idx;
   logic [NUM_CNT-1:0][2*DATA_W-1:0]    cnt_all;
   logic [NUM_CNT-1:0][EVT_W-1:0]       sel_all;
   logic [NUM_CNT-1:0]                  en_all;
   logic [DATA_W-1:0]                   ctl_rd;
   logic                                wr_ctl;

   assign space  = addr_space(csr_addr_i);
   assign idx    = addr_index(csr_addr_i);
   assign wr_ctl = csr_we_i && (space == SP_CTL);

   hpm_ctl #(.NUM_CNT(NUM_CNT)) i_ctl (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_i    (wr_ctl),
      .wdata_i (csr_wdata_i),
      .en_o    (en_all),
      .rd_o    (ctl_rd)
   );

   for (genvar k = 0; k < NUM_CNT; k++) begin : g_cnt
      logic hit;
      assign hit = csr_we_i && (idx == IDX_W'(k + FIRST_IDX));

      hpm_cell #(.EVT_W(EVT_W)) i_cell (
         .clk      (clk),
         .rst_n    (rst_n),
         .evt_i    (evt_i),
         .sleep_i  (sleep_i),
         .en_i     (en_all[k]),
         .wr_lo_i  (hit && space == SP_LO),
         .wr_hi_i  (hit && space == SP_HI),
         .wr_sel_i (hit && space == SP_SEL),
         .wdata_i  (csr_wdata_i),
         .cnt_o    (cnt_all[k]),
         .sel_o    (sel_all[k])
      );
   end

   hpm_rdmux #(.NUM_CNT(NUM_CNT), .EVT_W(EVT_W)) i_rdmux (
      .space_i (space),
      .idx_i   (idx),
      .cnt_i   (cnt_all),
      .sel_i   (sel_all),
      .ctl_i   (ctl_rd),
      .rdata_o (csr_rdata_o)
   );
endmodule

// File: rtl/hpm_bank_chk.sv
module hpm_bank_chk #(
   parameter int NUM_CNT = 4,
   parameter int EVT_W   = 8
) (
   input logic                                   clk,
   input logic                                   rst_n,
   input logic [EVT_W-1:0]                       evt_i,
   input logic                                   sleep_i,
   input logic                                   csr_we_i,
   input logic [hpm_pkg::ADDR_W-1:0]             csr_addr_i,
   input logic [hpm_pkg::DATA_W-1:0]             csr_rdata_o,
   input logic [NUM_CNT-1:0][2*hpm_pkg::DATA_W-1:0] cnt_all,
   input logic [NUM_CNT-1:0][EVT_W-1:0]          sel_all,
   input logic [NUM_CNT-1:0]                     en_all
);
   import hpm_pkg::*;

   logic unimpl;
   assign unimpl = (csr_addr_i[ADDR_W-1:IDX_W] != 2'b11) &&
                   ((csr_addr_i[IDX_W-1:0] < IDX_W'(FIRST_IDX)) ||
                    (csr_addr_i[IDX_W-1:0] >= IDX_W'(FIRST_IDX + NUM_CNT)));

   p_unimpl_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      unimpl |-> csr_rdata_o == '0);

   for (genvar k = 0; k < NUM_CNT; k++) begin : g_chk
      p_one_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
         !csr_we_i |=> (cnt_all[k] == $past(cnt_all[k]) ||
                        cnt_all[k] == $past(cnt_all[k]) + 64'd1));

      p_step_taken_r2: assert property (@(posedge clk) disable iff (!rst_n)
         (!csr_we_i && en_all[k] && !sleep_i && ((sel_all[k] & evt_i) != '0))
         |=> cnt_all[k] == $past(cnt_all[k]) + 64'd1);

      p_unselected_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (!csr_we_i && ((sel_all[k] & evt_i) == '0)) |=> $stable(cnt_all[k]));

      p_sleep_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (!csr_we_i && sleep_i) |=> $stable(cnt_all[k]));

      p_disabled_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (!csr_we_i && !en_all[k]) |=> $stable(cnt_all[k]));
   end
endmodule

bind hpm_bank hpm_bank_chk #(.NUM_CNT(NUM_CNT), .EVT_W(EVT_W)) i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .evt_i       (evt_i),
   .sleep_i     (sleep_i),
   .csr_we_i    (csr_we_i),
   .csr_addr_i  (csr_addr_i),
   .csr_rdata_o (csr_rdata_o),
   .cnt_all     (cnt_all),
   .sel_all     (sel_all),
   .en_all      (en_all)
);

// File: tb/test_hpm_bank.sv
module test_hpm_bank;
   localparam int NUM_CNT = 4;
   localparam int EVT_W   = 8;

   localparam logic [1:0] OP_WR  = 2'd0;
   localparam logic [1:0] OP_RUN = 2'd1;
   localparam logic [1:0] OP_CHK = 2'd2;

   typedef struct packed {
      logic [1:0]  op;
      logic [3:0]  req;
      logic [6:0]  addr;
      logic [31:0] data;
      logic [7:0]  evt;
      logic        slp;
   } vec_t;

   localparam int NV = 30;
   localparam vec_t VT [NV] = '{
      '{OP_WR,  4'd2,  7'h43, 32'h3,        8'h00, 1'b0}, // R2 selector idx3
      '{OP_WR,  4'd2,  7'h44, 32'h4,        8'h00, 1'b0}, // R2 selector idx4
      '{OP_WR,  4'd5,  7'h60, 32'h18,       8'h00, 1'b0}, // R5 enable 3,4
      '{OP_RUN, 4'd2,  7'h00, 32'd5,        8'h03, 1'b0}, // R2 two events at once
      '{OP_CHK, 4'd2,  7'h03, 32'd5,        8'h00, 1'b0}, // R2
      '{OP_CHK, 4'd3,  7'h04, 32'd0,        8'h00, 1'b0}, // R3
      '{OP_RUN, 4'd4,  7'h00, 32'd4,        8'h07, 1'b1}, // R4 asleep
      '{OP_CHK, 4'd4,  7'h03, 32'd5,        8'h00, 1'b0}, // R4
      '{OP_CHK, 4'd4,  7'h04, 32'd0,        8'h00, 1'b0}, // R4
      '{OP_RUN, 4'd2,  7'h00, 32'd3,        8'h05, 1'b0}, // R2
      '{OP_CHK, 4'd2,  7'h03, 32'd8,        8'h00, 1'b0}, // R2
      '{OP_CHK, 4'd2,  7'h04, 32'd3,        8'h00, 1'b0}, // R2
      '{OP_WR,  4'd5,  7'h60, 32'h10,       8'h00, 1'b0}, // R5 disable idx3
      '{OP_RUN, 4'd5,  7'h00, 32'd2,        8'h07, 1'b0}, // R5
      '{OP_CHK, 4'd5,  7'h03, 32'd8,        8'h00, 1'b0}, // R5
      '{OP_CHK, 4'd5,  7'h04, 32'd5,        8'h00, 1'b0}, // R5
      '{OP_WR,  4'd6,  7'h03, 32'hFFFFFFFE, 8'h00, 1'b0}, // R6 near wrap
      '{OP_WR,  4'd6,  7'h60, 32'h18,       8'h00, 1'b0}, // R6
      '{OP_RUN, 4'd6,  7'h00, 32'd2,        8'h01, 1'b0}, // R6
      '{OP_CHK, 4'd6,  7'h03, 32'd0,        8'h00, 1'b0}, // R6 low wrapped
      '{OP_CHK, 4'd6,  7'h23, 32'd1,        8'h00, 1'b0}, // R6 carry
      '{OP_WR,  4'd8,  7'h47, 32'hFF,       8'h00, 1'b0}, // R8 absent idx7
      '{OP_CHK, 4'd8,  7'h47, 32'd0,        8'h00, 1'b0}, // R8
      '{OP_CHK, 4'd8,  7'h42, 32'd0,        8'h00, 1'b0}, // R8
      '{OP_CHK, 4'd8,  7'h07, 32'd0,        8'h00, 1'b0}, // R8
      '{OP_WR,  4'd9,  7'h60, 32'hFFFFFFFF, 8'h00, 1'b0}, // R9
      '{OP_CHK, 4'd9,  7'h60, 32'h78,       8'h00, 1'b0}, // R9 bits 3..6
      '{OP_WR,  4'd9,  7'h45, 32'hFFFFFF81, 8'h00, 1'b0}, // R9
      '{OP_CHK, 4'd9,  7'h45, 32'h81,       8'h00, 1'b0}, // R9
      '{OP_CHK, 4'd10, 7'h44, 32'h4,        8'h00, 1'b0}  // R10 selector space
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  evt = '0;
   logic        sleep = 1'b0;
   logic        we = 1'b0;
   logic [6:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;

   int n_chk = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   hpm_bank #(.NUM_CNT(NUM_CNT), .EVT_W(EVT_W)) i_hpm_bank (
      .clk         (clk),
      .rst_n       (rst_n),
      .evt_i       (evt),
      .sleep_i     (sleep),
      .csr_we_i    (we),
      .csr_addr_i  (addr),
      .csr_wdata_i (wdata),
      .csr_rdata_o (rdata)
   );

   task automatic wr(input logic [6:0] a, input logic [31:0] d, input logic [7:0] e);
      @(negedge clk);
      we = 1'b1; addr = a; wdata = d; evt = e;
      @(negedge clk);
      we = 1'b0; evt = '0;
   endtask

   task automatic run(input int n, input logic [7:0] e, input logic s);
      @(negedge clk);
      evt = e; sleep = s;
      repeat (n) @(negedge clk);
      evt = '0; sleep = 1'b0;
   endtask

   task automatic chk(input logic [6:0] a, input logic [31:0] exp, input string tag);
      @(negedge clk);
      addr = a;
      #1;
      n_chk++;
      if (rdata !== exp) begin
         n_fail++;
         $display("FAIL %s addr=%h actual=%h expected=%h", tag, a, rdata, exp);
      end
   endtask

   initial begin
      #(5ns * 150000);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      chk(7'h03, 32'd0, "R1 low");
      chk(7'h43, 32'd0, "R1 sel");
      chk(7'h60, 32'd0, "R1 ctl");

      for (int i = 0; i < NV; i++) begin
         case (VT[i].op)
            OP_WR:   wr(VT[i].addr, VT[i].data, 8'h00);
            OP_RUN:  run(int'(VT[i].data), VT[i].evt, VT[i].slp);
            default: chk(VT[i].addr, VT[i].data, $sformatf("R%0d vec%0d", VT[i].req, i));
         endcase
      end

      // R7: write to low word beats a same-cycle increment; high holds
      wr(7'h03, 32'd100, 8'h01);
      chk(7'h03, 32'd100, "R7 low write wins");
      chk(7'h23, 32'd1,   "R7 high held");
      wr(7'h23, 32'd7, 8'h01);
      chk(7'h23, 32'd7,   "R7 high write wins");
      chk(7'h03, 32'd100, "R7 low held");
      run(1, 8'h01, 1'b0);
      chk(7'h03, 32'd101, "R7 counting resumes");

      // R1: reset in mid-operation
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      chk(7'h03, 32'd0, "R1 low after reset");
      chk(7'h23, 32'd0, "R1 high after reset");
      chk(7'h44, 32'd0, "R1 sel after reset");
      chk(7'h60, 32'd0, "R1 ctl after reset");

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule